// File: doc/BRIEF.md
# Clause-22 PHY Management Register

This block gives software one 32-bit register through which it reaches a single external PHY. A write to the register starts one clause-22 management frame on the MDC/MDIO pair. The value of bit 31 in that write picks the direction of the frame. Software then polls the same register until bit 31 shows that the frame has finished.

For a write frame, software sets bit 31. The bit stays set while the frame shifts out and drops when the frame ends. For a read frame, software clears bit 31. The bit stays clear until the PHY's 16 data bits have been captured, and then it rises with the data in the low half-word. The PHY address is a build-time parameter. MDC is made from the system clock by a divider and sits low between frames. The MDIO line is driven through a separate output enable, which is released during the read part of a read frame.

Top module: `mdio_mgmt_reg`

## Requirements
- R1: After reset, host_rdata is all zero, mdc is low and mdio_oe is low.
- R2: Readback places the busy/done flag in bit 31, the 8-bit register address field in bits 23:16 and the data field in bits 15:0. Bits 30:24 always read zero, whatever was written to them.
- R3: A host write with bit 31 = 1 sends, MSB first, a 64-bit frame: 32 ones, start 01, opcode 01, the 5-bit PHY_ADDR, the 5-bit register number, turnaround 10, then data bits 15:0. Bit 31 reads 1 until the frame completes and 0 afterwards.
- R4: A host write with bit 31 = 0 sends 32 ones, start 01, opcode 10, PHY_ADDR and the register number. It holds mdio_oe high for frame bits 0..45 and low for bits 46..63. At completion it loads the received word into bits 15:0 and sets bit 31.
- R5: On a read frame, mdio_i is sampled on the rising edge of mdc for frame bits 48..63, and the first sampled bit is data bit 15.
- R6: Only address field bits 4:0 enter the frame as the register number. Bits 7:5 are kept in readback but never reach the line. Registers 0, 1, 4 and 9 are reachable like any other.
- R7: Each mdc half period lasts CLK_DIV system clocks, and a frame lasts 128*CLK_DIV clocks from the accepting edge. mdc is low whenever no frame is active.
- R8: A host write that arrives while a frame is in progress is ignored: the register contents, the frame on the line and the idle state that follows are unchanged.
- R9: mdio_o changes only together with a falling edge of mdc, so it is stable while mdc is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe, one cycle |
| host_wdata | input | 32 | Register write value |
| host_rdata | output | 32 | Register readback value |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data received from the PHY |

## Verification
The bench builds the block with CLK_DIV = 2 and PHY_ADDR = 5'h13. The short divider keeps a full frame at 256 clocks, so every one of the 32 register numbers can be written and then read back within the cycle budget. It also makes the clock-exact frame length and the half-period checkable. The PHY address, which is neither zero nor all ones, shows that the address bits land in the right frame positions. Address fields with non-zero upper bits and writes aimed at the middle of a frame cover the truncation and ignore rules.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
   localparam int FRAME_BITS = 64;
   localparam int PRE_BITS   = 32;
   localparam int TA_FIRST   = 46;   // first turnaround bit index
   localparam int DATA_FIRST = 48;   // first data bit index
   localparam int DATA_W     = 16;
   localparam int REG_W      = 5;

   typedef enum logic [1:0] {
      OPC_WR = 2'b01,
      OPC_RD = 2'b10
   } mdio_opc_e;

   typedef struct packed {
      logic        flag;
      logic [7:0]  addr;
      logic [15:0] data;
   } mgmt_reg_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int CLK_DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_evt,
   output logic fall_evt
);
   logic phase_end;
   logic mdc_q;

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (CLK_DIV == 1) begin : g_nodiv
         assign phase_end = run;
      end else begin : g_div
         localparam int CW = $clog2(CLK_DIV);
         localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (!run)           cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end
         assign phase_end = run && (cnt_q == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mdc_q <= 1'b0;
      else if (!run)      mdc_q <= 1'b0;
      else if (phase_end) mdc_q <= ~mdc_q;
   end

   assign mdc      = mdc_q;
   assign rise_evt = phase_end && !mdc_q;
   assign fall_evt = phase_end &&  mdc_q;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
   import mdio_mgmt_pkg::*;
#(
   parameter logic [4:0] PHY_ADDR = 5'd1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                start_rd,
   input  logic [REG_W-1:0]    start_reg,
   input  logic [DATA_W-1:0]   start_data,
   input  logic                rise_evt,
   input  logic                fall_evt,
   input  logic                mdio_i,
   output logic                busy,
   output logic                done,
   output logic [DATA_W-1:0]   rx_data,
   output logic                mdio_o,
   output logic                mdio_oe
);
   localparam int IDX_W = $clog2(FRAME_BITS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
   localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_FIRST);
   localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_FIRST);

   logic                  busy_q;
   logic                  rd_q;
   logic [IDX_W-1:0]      idx_q;
   logic [FRAME_BITS-1:0] tx_sr;
   logic [DATA_W-1:0]     rx_sr;
   logic [FRAME_BITS-1:0] frame_new;
   mdio_opc_e             opc;

   always_comb begin
      opc = start_rd ? OPC_RD : OPC_WR;
      frame_new = {{PRE_BITS{1'b1}}, 2'b01, opc, PHY_ADDR, start_reg,
                   (start_rd ? 2'b11 : 2'b10),
                   (start_rd ? {DATA_W{1'b1}} : start_data)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rd_q   <= 1'b0;
         idx_q  <= '0;
         tx_sr  <= '1;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            rd_q   <= start_rd;
            idx_q  <= '0;
            tx_sr  <= frame_new;
         end
      end else if (fall_evt) begin
         if (idx_q == LAST_IDX) begin
            busy_q <= 1'b0;
            tx_sr  <= '1;
         end else begin
            idx_q <= idx_q + 1'b1;
            tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b1};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_sr <= '0;
      else if (busy_q && rd_q && rise_evt && idx_q >= DAT_IDX)
         rx_sr <= {rx_sr[DATA_W-2:0], mdio_i};
   end

   assign busy    = busy_q;
   assign done    = busy_q && fall_evt && (idx_q == LAST_IDX);
   assign rx_data = rx_sr;
   assign mdio_o  = tx_sr[FRAME_BITS-1];
   assign mdio_oe = busy_q && !(rd_q && idx_q >= TA_IDX);
endmodule

// File: rtl/mdio_mgmt_reg.sv
module mdio_mgmt_reg
   import mdio_mgmt_pkg::*;
#(
   parameter int         CLK_DIV  = 8,
   parameter logic [4:0] PHY_ADDR = 5'd1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_wr,
   input  logic [31:0] host_wdata,
   output logic [31:0] host_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   mgmt_reg_t        reg_q;
   logic             op_rd_q;
   logic             eng_busy;
   logic             eng_done;
   logic [DATA_W-1:0] eng_rx;
   logic             rise_evt;
   logic             fall_evt;
   logic             accept;

   assign accept = host_wr && !eng_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q   <= '0;
         op_rd_q <= 1'b0;
      end else if (accept) begin
         reg_q.flag <= host_wdata[31];
         reg_q.addr <= host_wdata[23:16];
         reg_q.data <= host_wdata[15:0];
         op_rd_q    <= !host_wdata[31];
      end else if (eng_done) begin
         if (op_rd_q) begin
            reg_q.flag <= 1'b1;
            reg_q.data <= eng_rx;
         end else begin
            reg_q.flag <= 1'b0;
         end
      end
   end

   assign host_rdata = {reg_q.flag, 7'b0, reg_q.addr, reg_q.data};

   mdio_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (eng_busy),
      .mdc      (mdc),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   mdio_frame_eng #(.PHY_ADDR(PHY_ADDR)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .start_rd   (!host_wdata[31]),
      .start_reg  (host_wdata[16 +: REG_W]),
      .start_data (host_wdata[15:0]),
      .rise_evt   (rise_evt),
      .fall_evt   (fall_evt),
      .mdio_i     (mdio_i),
      .busy       (eng_busy),
      .done       (eng_done),
      .rx_data    (eng_rx),
      .mdio_o     (mdio_o),
      .mdio_oe    (mdio_oe)
   );

   AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> !mdc); // R7
   AST_MDIO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy && $past(eng_busy) && !$stable(mdio_o) |-> !mdc); // R9
   AST_FIELDS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |=> $stable(reg_q.addr)); // R8
   AST_WR_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eng_busy) && !op_rd_q |-> !host_rdata[31]); // R3
   AST_RD_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eng_busy) && op_rd_q |-> host_rdata[31]); // R4
endmodule

// File: tb/mdio_mgmt_reg_tb.sv
module mdio_mgmt_reg_tb_top;
   localparam int         DIV = 2;
   localparam logic [4:0] PHY = 5'h13;
   localparam int         FRAME_CLKS = 128 * DIV;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int vectors = 0;
   int fails = 0;
   int cyc = 0;

   // PHY model state
   int          bitcnt = 0;
   logic [63:0] cap_o, cap_oe;
   logic [15:0] phy_rd = '0;
   int          last_rise = 0;
   int          period_bad = 0;

   always #5 clk = ~clk;
   always @(negedge clk) cyc++;

   mdio_mgmt_reg #(.CLK_DIV(DIV), .PHY_ADDR(PHY)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i));

   always @(posedge mdc) begin
      if (bitcnt < 64) begin
         cap_o[63-bitcnt]  = mdio_o;
         cap_oe[63-bitcnt] = mdio_oe;
      end
      if (bitcnt > 0 && (cyc - last_rise) != 2*DIV) period_bad++;
      last_rise = cyc;
   end

   always @(negedge mdc) begin
      bitcnt++;
      if (bitcnt >= 48 && bitcnt <= 63) mdio_i = phy_rd[63-bitcnt];
      else mdio_i = 1'b1;
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [31:0] v);
      @(negedge clk);
      host_wr = 1'b1; host_wdata = v;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   // Runs one transaction; returns negedges from write to flag flip
   task automatic run_txn(input logic [31:0] v, output int waited);
      bitcnt = 0; period_bad = 0; cap_o = '0; cap_oe = '0;
      host_write(v);
      waited = 1;
      while (host_rdata[31] == v[31] && waited < 4000) begin
         @(negedge clk);
         waited++;
      end
      if (waited >= 4000) begin
         fails++;
         $display("FAIL watchdog: transaction hung");
      end
   endtask

   function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] r,
                                             input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), PHY, r,
              (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : d)};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: global timeout");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      int w;
      logic [63:0] ef;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(host_rdata == 32'h0 && !mdc && !mdio_oe, "R1",
            {host_rdata, 29'b0, mdc, mdio_oe, 1'b0}, 64'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int r = 0; r < 32; r++) begin
         logic [7:0]  a8;
         logic [15:0] wd;
         a8 = {r[2:0], r[4:0]};
         wd = 16'(r * 16'h9E37) ^ 16'h5A5A;
         // R3 write frame, reserved bits written as ones (R2), upper address bits (R6)
         run_txn({1'b1, 7'h7F, a8, wd}, w);
         ef = exp_frame(1'b0, r[4:0], wd);
         check(cap_o == ef, "R3 write frame (R6 reg number)", cap_o, ef);
         check(cap_oe == '1, "R3 write oe", cap_oe, '1);
         check(host_rdata == {1'b0, 7'h0, a8, wd}, "R2 R3 write readback",
               {32'h0, host_rdata}, {32'h0, 1'b0, 7'h0, a8, wd});
         check(w == FRAME_CLKS + 1 && period_bad == 0, "R7 frame length/half period",
               64'(w), 64'(FRAME_CLKS + 1));
         // R4/R5 read
         phy_rd = 16'(r * 16'h3C4D) ^ 16'hA5C3;
         run_txn({1'b0, 7'h7F, a8, 16'hFFFF}, w);
         ef = exp_frame(1'b1, r[4:0], 16'h0);
         check(cap_o[63:18] == ef[63:18], "R4 read frame header",
               {18'h0, cap_o[63:18]}, {18'h0, ef[63:18]});
         check(cap_oe == {46'h3FFF_FFFF_FFFF, 18'h0}, "R4 read oe release",
               cap_oe, {46'h3FFF_FFFF_FFFF, 18'h0});
         check(host_rdata == {1'b1, 7'h0, a8, phy_rd}, "R5 R4 read result",
               {32'h0, host_rdata}, {32'h0, 1'b1, 7'h0, a8, phy_rd});
         check(!mdc && !mdio_oe, "R7 idle low", {62'h0, mdc, mdio_oe}, 64'h0);
      end

      // R8: write in mid-frame is ignored
      bitcnt = 0; cap_o = '0;
      host_write({1'b1, 7'h0, 8'h09, 16'h1234});
      repeat (40) @(negedge clk);
      host_write({1'b0, 7'h0, 8'h04, 16'hBEEF});
      check(host_rdata == 32'h8009_1234, "R8 busy write ignored (readback)",
            {32'h0, host_rdata}, 64'h8009_1234);
      w = 0;
      while (host_rdata[31] && w < 4000) begin @(negedge clk); w++; end
      ef = exp_frame(1'b0, 5'd9, 16'h1234);
      check(cap_o == ef, "R8 frame unaffected", cap_o, ef);
      check(host_rdata == 32'h0009_1234, "R8 final readback",
            {32'h0, host_rdata}, 64'h0009_1234);
      repeat (50) @(negedge clk);
      check(bitcnt == 64 && !mdc && !mdio_oe, "R8 no second frame",
            64'(bitcnt), 64'd64);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule